// File: doc/BRIEF.md
# Watchdog Timer with Magic-Word Restart

This block is a bus-attached watchdog. A 32-bit down-counter is loaded from a programmable preload register. Firmware proves it is alive by writing one exact key word to a dedicated kick register, which reloads the counter. If firmware stops kicking, the counter runs out. The block then emits one-cycle pulses on whichever expiry outputs the control word enables: a system reset request, an interrupt, or an external alarm line. The reset scope (SoC only or full chip) is driven alongside the reset request.

The counter either steps on every bus clock or on a slow tick of about 1 MHz. The slow tick comes from an internal prescaler whose ratio is derived from two frequency parameters. A kick also clears the prescaler, so the first slow interval after a kick is exactly one full prescaler period. All registers use single-cycle accesses. Read data is registered and appears the cycle after the read strobe.

Register offsets (byte addresses): 0x0 live count (read only), 0x4 preload (read/write), 0x8 kick (write only, reads zero), 0xC control (read/write). Control bits: [0] run, [1] reset-request enable, [2] interrupt enable, [3] alarm-line enable, [4] slow-tick select (1 = prescaled tick, 0 = every clock), [6:5] reset scope (0 = SoC, 1 = full chip). Bits 31:7 read as zero.

Top module: `watchdog_core`

## Requirements
- R1: After reset every register reads zero, the timer is stopped, and all expiry outputs and `rst_scope` are zero.
- R2: The preload register at 0x4 reads back all 32 written bits. The control register at 0xC reads back bits 6:0 of the written word, with bits 31:7 read as zero.
- R3: Writing exactly 0x00004755 to offset 0x8 loads the counter from the preload register, whether or not the timer runs. A read of offset 0x0 returns the counter value as it stood at the clock edge of the read strobe.
- R4: A write of any other value to offset 0x8 leaves the counter unchanged.
- R5: While control bit 0 is clear the counter holds its value.
- R6: With control bit 0 set and bit 4 clear, the counter decrements by one on every clock.
- R7: With control bits 0 and 4 set, the counter decrements once every DIV clocks, where DIV = CLK_HZ / TICK_HZ. A kick clears the prescaler, so the first decrement comes DIV clocks after the kick edge.
- R8: A tick that finds the counter at zero is an expiry. The counter reloads from the preload register instead of decrementing, so an expiry repeats every preload+1 ticks. The enabled expiry outputs pulse high for exactly the one cycle after the expiring edge.
- R9: `sys_rst_req` pulses only if control bit 1 is set, `irq` only if bit 2 is set, and `alarm` only if bit 3 is set. Each enable acts independently of the others.
- R10: `rst_scope` carries control bits 6:5 during a `sys_rst_req` pulse and is zero otherwise.
- R11: When a valid kick falls on the same edge as an expiry tick, the kick wins. The counter loads the preload value and no expiry output pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_re | input | 1 | Read strobe, data returned next cycle |
| bus_rdata | output | DATA_W | Registered read data |
| sys_rst_req | output | 1 | One-cycle reset request on expiry |
| irq | output | 1 | One-cycle interrupt pulse on expiry |
| alarm | output | 1 | One-cycle external alarm pulse on expiry |
| rst_scope | output | 2 | Reset scope valid with `sys_rst_req` |

## Verification
Two events can land on the same clock edge: a firmware kick and an expiry tick of a counter already at zero. The bench enables fast stepping with a small preload and counts clocks so that the kick write strikes exactly the edge on which the counter would expire. It then judges two things: no expiry output rises, and the next status read returns the full preload value. A second pass sends a wrong key on the same edge and expects the pulse to appear, which shows the timing really hit the expiry edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int OFF_COUNT   = 'h0;
  localparam int OFF_PRELOAD = 'h4;
  localparam int OFF_KICK    = 'h8;
  localparam int OFF_CTRL    = 'hC;

  localparam logic [15:0] KICK_KEY = 16'h4755;

  typedef struct packed {
    logic [1:0] scope;
    logic       slow;
    logic       alarm_en;
    logic       irq_en;
    logic       rst_en;
    logic       run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/wdog_regfile.sv
module wdog_regfile
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [DATA_W-1:0] count,
  output ctrl_t             ctrl_q,
  output logic [DATA_W-1:0] preload_q,
  output logic              kick,
  output logic [DATA_W-1:0] rdata
);

  localparam logic [DATA_W-1:0] KEY_WORD = DATA_W'(KICK_KEY);

  logic sel_preload, sel_kick, sel_ctrl, sel_count;
  logic [DATA_W-1:0] rd_val;

  assign sel_count   = (addr == ADDR_W'(OFF_COUNT));
  assign sel_preload = (addr == ADDR_W'(OFF_PRELOAD));
  assign sel_kick    = (addr == ADDR_W'(OFF_KICK));
  assign sel_ctrl    = (addr == ADDR_W'(OFF_CTRL));

  assign kick = we && sel_kick && (wdata == KEY_WORD);

  always_comb begin
    rd_val = '0;
    if (sel_count)   rd_val = count;
    if (sel_preload) rd_val = preload_q;
    if (sel_ctrl)    rd_val[CTRL_W-1:0] = ctrl_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      preload_q <= '0;
      rdata     <= '0;
    end else begin
      if (we && sel_preload) preload_q <= wdata;
      if (we && sel_ctrl)    ctrl_q    <= ctrl_t'(wdata[CTRL_W-1:0]);
      rdata <= re ? rd_val : '0;
    end
  end

endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int DIV = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clear,
  output logic tick
);

  generate
    if (DIV <= 1) begin : g_bypass
      assign tick = run && !clear;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] phase;

      assign tick = run && !clear && (phase == LAST);

      always_ff @(posedge clk) begin
        if (rst || clear || !run) phase <= '0;
        else if (phase == LAST)   phase <= '0;
        else                      phase <= phase + 1'b1;
      end
    end
  endgenerate

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             kick,
  input  logic [CNT_W-1:0] preload,
  output logic [CNT_W-1:0] count,
  output logic             expire
);

  logic at_zero;

  assign at_zero = (count == '0);
  assign expire  = tick && at_zero && !kick;

  always_ff @(posedge clk) begin
    if (rst)                count <= '0;
    else if (kick)          count <= preload;
    else if (expire)        count <= preload;
    else if (tick)          count <= count - 1'b1;
  end

endmodule

// File: rtl/wdog_actions.sv
module wdog_actions
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       expire,
  input  ctrl_t      ctrl,
  output logic       sys_rst_req,
  output logic       irq,
  output logic       alarm,
  output logic [1:0] rst_scope
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sys_rst_req <= 1'b0;
      irq         <= 1'b0;
      alarm       <= 1'b0;
      rst_scope   <= 2'b00;
    end else begin
      sys_rst_req <= expire && ctrl.rst_en;
      irq         <= expire && ctrl.irq_en;
      alarm       <= expire && ctrl.alarm_en;
      rst_scope   <= (expire && ctrl.rst_en) ? ctrl.scope : 2'b00;
    end
  end

endmodule

// File: rtl/watchdog_core.sv
module watchdog_core
  import wdog_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int CLK_HZ  = 200_000_000,
  parameter int TICK_HZ = 1_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sys_rst_req,
  output logic              irq,
  output logic              alarm,
  output logic [1:0]        rst_scope
);

  localparam int DIV = (CLK_HZ / TICK_HZ < 1) ? 1 : CLK_HZ / TICK_HZ;

  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] preload_q;
  logic [DATA_W-1:0] count_q;
  logic              kick;
  logic              slow_tick;
  logic              tick;
  logic              expire;

  wdog_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .addr      (bus_addr),
    .we        (bus_we),
    .wdata     (bus_wdata),
    .re        (bus_re),
    .count     (count_q),
    .ctrl_q    (ctrl_q),
    .preload_q (preload_q),
    .kick      (kick),
    .rdata     (bus_rdata)
  );

  wdog_prescaler #(.DIV(DIV)) u_presc (
    .clk   (clk),
    .rst   (rst),
    .run   (ctrl_q.run && ctrl_q.slow),
    .clear (kick),
    .tick  (slow_tick)
  );

  assign tick = ctrl_q.run && (ctrl_q.slow ? slow_tick : 1'b1);

  wdog_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .kick    (kick),
    .preload (preload_q),
    .count   (count_q),
    .expire  (expire)
  );

  wdog_actions u_act (
    .clk         (clk),
    .rst         (rst),
    .expire      (expire),
    .ctrl        (ctrl_q),
    .sys_rst_req (sys_rst_req),
    .irq         (irq),
    .alarm       (alarm),
    .rst_scope   (rst_scope)
  );

endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              run,
  input logic              irq_en,
  input logic              kick,
  input logic              expire,
  input logic [DATA_W-1:0] count,
  input logic [DATA_W-1:0] preload,
  input logic              sys_rst_req,
  input logic              irq,
  input logic              alarm,
  input logic [1:0]        rst_scope
);

  // R3: a valid kick loads the preload value
  assert_kick_loads_R3: assert property (@(posedge clk) disable iff (rst)
    kick |=> count == $past(preload));

  // R5: a stopped timer holds its count
  assert_hold_stopped_R5: assert property (@(posedge clk) disable iff (rst)
    (!run && !kick) |=> count == $past(count));

  // R8: expiry reloads the counter
  assert_reload_on_expiry_R8: assert property (@(posedge clk) disable iff (rst)
    expire |=> count == $past(preload));

  // R9: interrupt only when its enable was set
  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(irq_en));

  // R10: scope is quiet without a reset request
  assert_scope_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !sys_rst_req |-> rst_scope == 2'b00);

  // R11: a kick suppresses every expiry output
  assert_kick_wins_R11: assert property (@(posedge clk) disable iff (rst)
    kick |=> !(sys_rst_req || irq || alarm));

endmodule

bind watchdog_core wdog_checker #(.DATA_W(DATA_W)) u_wdog_checker (
  .clk         (clk),
  .rst         (rst),
  .run         (ctrl_q.run),
  .irq_en      (ctrl_q.irq_en),
  .kick        (kick),
  .expire      (expire),
  .count       (count_q),
  .preload     (preload_q),
  .sys_rst_req (sys_rst_req),
  .irq         (irq),
  .alarm       (alarm),
  .rst_scope   (rst_scope)
);

// File: tb/watchdog_core_bench.sv
`timescale 1ns/1ps
module watchdog_core_bench;

  localparam int DIV = 4;
  localparam logic [3:0] A_CNT = 4'h0, A_PRE = 4'h4, A_KICK = 4'h8, A_CTRL = 4'hC;
  localparam logic [31:0] KEY = 32'h0000_4755;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        sys_rst_req, irq, alarm;
  logic [1:0]  rst_scope;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  watchdog_core #(.CLK_HZ(4_000_000), .TICK_HZ(1_000_000)) u_watchdog_core (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .sys_rst_req(sys_rst_req), .irq(irq), .alarm(alarm), .rst_scope(rst_scope)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    d = bus_rdata;
    bus_re = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] outs();
    return {27'd0, rst_scope, alarm, irq, sys_rst_req};
  endfunction

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    idle(3);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    rd(A_CNT, v);  check("R1 count", v, 0);
    rd(A_PRE, v);  check("R1 preload", v, 0);
    rd(A_KICK, v); check("R1 kick", v, 0);
    rd(A_CTRL, v); check("R1 ctrl", v, 0);
    check("R1 outputs", outs(), 0);

    // R2: readback
    wr(A_PRE, 32'hA5A5_1234); rd(A_PRE, v); check("R2 preload", v, 32'hA5A5_1234);
    wr(A_CTRL, 32'hFFFF_FFFE); rd(A_CTRL, v); check("R2 ctrl", v, 32'h7E);
    wr(A_CTRL, 32'h0); rd(A_CTRL, v); check("R2 ctrl clear", v, 0);

    // R3/R4/R5: kick with key, wrong keys ignored, stopped timer holds
    wr(A_PRE, 7); wr(A_KICK, KEY); rd(A_CNT, v); check("R3 kick load", v, 7);
    wr(A_PRE, 9);
    wr(A_KICK, 32'h0000_4756); rd(A_CNT, v); check("R4 wrong key", v, 7);
    wr(A_KICK, 32'h0001_4755); rd(A_CNT, v); check("R4 upper bits", v, 7);
    idle(10); rd(A_CNT, v); check("R5 hold stopped", v, 7);
    wr(A_KICK, KEY); rd(A_CNT, v); check("R3 new preload", v, 9);

    // R6/R8/R9/R10: fast-mode sweep over preloads and action masks
    for (int k = 0; k < 4; k++) begin
      int n;
      logic [2:0] mask;
      logic [1:0] scope;
      n = (k == 3) ? 5 : k;
      mask = 3'((k * 3 + 1) % 8);
      scope = 2'(k);
      wr(A_CTRL, 0); wr(A_PRE, 32'(n)); wr(A_KICK, KEY);
      wr(A_CTRL, {25'd0, scope, 1'b0, mask, 1'b1});
      for (int j = 1; j <= 2 * (n + 1) + 1; j++) begin
        logic pulse;
        logic [31:0] exp_o;
        rd(A_CNT, v);
        check("R6 fast count", v, 32'(n - ((j - 1) % (n + 1))));
        pulse = (((j - 1) % (n + 1)) == n);
        exp_o = {27'd0, (pulse && mask[0]) ? scope : 2'b00,
                 pulse && mask[2], pulse && mask[1], pulse && mask[0]};
        check("R8 R9 R10 expiry outputs", outs(), exp_o);
      end
    end

    // R7: slow tick with prescaler cleared by kick
    wr(A_CTRL, 0); wr(A_PRE, 10); wr(A_KICK, KEY);
    wr(A_CTRL, 32'h11);
    for (int j = 1; j <= 3 * DIV; j++) begin
      rd(A_CNT, v); check("R7 slow count", v, 32'(10 - (j - 1) / DIV));
    end
    idle(2);
    wr(A_KICK, KEY);
    for (int j = 1; j <= 3 * DIV; j++) begin
      rd(A_CNT, v); check("R7 after kick", v, 32'(10 - (j - 1) / DIV));
    end

    // R11: kick on the expiring edge wins
    wr(A_CTRL, 0); wr(A_PRE, 3); wr(A_KICK, KEY);
    wr(A_CTRL, 32'h2F);
    idle(3);
    wr(A_KICK, KEY);
    check("R11 no pulse", outs(), 0);
    rd(A_CNT, v); check("R11 count reloaded", v, 3);
    // same timing with a wrong key: expiry must fire
    wr(A_CTRL, 0); wr(A_KICK, KEY);
    wr(A_CTRL, 32'h2F);
    idle(3);
    wr(A_KICK, 32'h1234);
    check("R11 control pulse", outs(), {27'd0, 2'b01, 3'b111});

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule